// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block is the digital side of an on-chip analog comparator. It drives the select line of the mux in front of the comparator's positive input, which picks either an external pin or an internal fixed reference. It brings the comparator's free-running output into the clock domain through a flop chain and shows the result as a read-only status bit. A two-bit mode field chooses which changes of that output count as events: either edge, falling edges only or rising edges only. One code of the mode field is reserved.

A detected event sets a sticky flag. Software clears the flag by writing a one to its bit. The flag also clears when the interrupt is acknowledged. The interrupt request is raised only while the flag, a local enable and a global enable input are all high. A routing bit, when set, forwards the synchronized comparator output to a timer's capture trigger input. When the bit is clear, that output is held low.

Software sees one control/status word. Write-data bits: 0 reference select, 1 interrupt enable, 2 capture routing, 4:3 mode, 5 flag clear (write one to clear). The read word uses the same positions, with the flag state at bit 5 and the synchronized comparator level at bit 6.

Top module: `cmp_event_irq`

## Requirements
- R1: The status bit (read bit 6) takes the value of `cmp_raw_i` two rising clock edges after the input changes, and not after one.
- R2: With mode 00, both a rising and a falling change of the synchronized output set the flag (read bit 5) one edge after the status bit changes. A level that stays steady does not set the flag again.
- R3: With mode 01 (reserved), no change of the comparator output sets the flag.
- R4: With mode 10, a falling change sets the flag and a rising change does not.
- R5: With mode 11, a rising change sets the flag and a falling change does not.
- R6: Writing a one to bit 5 clears the flag, and so does a pulse on `irq_ack_i`. Writing a zero to bit 5 leaves the flag unchanged. When an event and a clear fall in the same cycle, the flag ends up set.
- R7: `irq_o` is high exactly when the flag, the interrupt enable (bit 1) and `gie_i` are all high.
- R8: `ref_sel_o` follows the reference-select bit (bit 0). A one selects the internal reference.
- R9: When the routing bit (bit 2) is set, `capt_trig_o` follows the synchronized comparator output. When the bit is clear, `capt_trig_o` stays low.
- R10: After reset every read bit is zero. The written bits 4:0 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw_i | input | 1 | Asynchronous comparator output |
| gie_i | input | 1 | Global interrupt enable |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 6 | Write data |
| reg_rdata_o | output | 7 | Read-back of control and status |
| irq_ack_i | input | 1 | Interrupt vector acknowledge, clears the flag |
| irq_o | output | 1 | Interrupt request |
| ref_sel_o | output | 1 | Positive-input mux select to the analog side |
| capt_trig_o | output | 1 | Trigger to the timer capture unit |

## Verification
A stale previous-sample register shows up at the ports as a flag that is set when it should not be, or not set when it should be. This is visible on bit 5 one edge after the status bit changes, or right after a mode write. A synchronizer stage that is too short or too long moves the status bit one edge early or late. For that reason the bench samples the status bit after the first edge and again after the second. A clear that takes priority over the hardware set loses an event, and this shows up as a clear flag in the cycle after an acknowledge that coincided with an edge.

// File: rtl/cmp_event_pkg.sv
// Shared constants for the comparator event interrupt controller.
// Assumes a single control word with the bit positions listed below.
package cmp_event_pkg;
    localparam int WR_W      = 6;
    localparam int RD_W      = 7;
    localparam int B_REF     = 0;
    localparam int B_IEN     = 1;
    localparam int B_ROUTE   = 2;
    localparam int B_MODE_LO = 3;
    localparam int B_MODE_HI = 4;
    localparam int B_FLAG    = 5;
    localparam int B_STAT    = 6;

    typedef enum logic [1:0] {
        MODE_ANY  = 2'b00,
        MODE_RSVD = 2'b01,
        MODE_FALL = 2'b10,
        MODE_RISE = 2'b11
    } evt_mode_e;
endpackage

// File: rtl/cmp_sync.sv
// Multi-flop synchronizer for one asynchronous bit.
// Assumes STAGES >= 2. Output latency is STAGES clock edges.
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
// Mode-selected edge detector for the synchronized comparator output.
// Compares each sample with the previous one, so one change yields one
// single-cycle event. The reserved mode produces no events.
module cmp_edge_det
    import cmp_event_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp_i,
    input  evt_mode_e mode_i,
    output logic      evt_o
);
    logic prev_q;
    logic rise, fall;

    // Hold the previous synchronized sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp_i;
    end

    assign rise = smp_i & ~prev_q;
    assign fall = ~smp_i & prev_q;

    // Pick the event kind from the mode field.
    always_comb begin
        unique case (mode_i)
            MODE_ANY:  evt_o = rise | fall;
            MODE_FALL: evt_o = fall;
            MODE_RISE: evt_o = rise;
            default:   evt_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmp_flag_ctl.sv
// Sticky event flag. A hardware set takes priority over any clear in the
// same cycle, so no event is lost.
module cmp_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Update the flag: set wins, then clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/cmp_event_irq.sv
// Top level of the comparator event interrupt controller. Holds the
// control bits, drives the reference mux select and the capture trigger,
// and gates the interrupt request. Assumes the register write is a
// single-cycle strobe in the clk domain.
module cmp_event_irq
    import cmp_event_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmp_raw_i,
    input  logic            gie_i,
    input  logic            reg_wr_i,
    input  logic [WR_W-1:0] reg_wdata_i,
    output logic [RD_W-1:0] reg_rdata_o,
    input  logic            irq_ack_i,
    output logic            irq_o,
    output logic            ref_sel_o,
    output logic            capt_trig_o
);
    logic      ref_q, ien_q, route_q;
    evt_mode_e mode_q;
    logic      cmp_s;
    logic      evt;
    logic      flag_q;
    logic      flag_clr;

    // Capture the control bits on a register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= 1'b0;
            ien_q   <= 1'b0;
            route_q <= 1'b0;
            mode_q  <= MODE_ANY;
        end else if (reg_wr_i) begin
            ref_q   <= reg_wdata_i[B_REF];
            ien_q   <= reg_wdata_i[B_IEN];
            route_q <= reg_wdata_i[B_ROUTE];
            mode_q  <= evt_mode_e'(reg_wdata_i[B_MODE_HI:B_MODE_LO]);
        end
    end

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_raw_i),
        .q_o   (cmp_s)
    );

    cmp_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (cmp_s),
        .mode_i (mode_q),
        .evt_o  (evt)
    );

    assign flag_clr = irq_ack_i | (reg_wr_i & reg_wdata_i[B_FLAG]);

    cmp_flag_ctl u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt),
        .clr_i  (flag_clr),
        .flag_o (flag_q)
    );

    assign irq_o       = flag_q & ien_q & gie_i;
    assign ref_sel_o   = ref_q;
    assign capt_trig_o = route_q & cmp_s;
    assign reg_rdata_o = {cmp_s, flag_q, mode_q, route_q, ien_q, ref_q};
endmodule

// File: rtl/cmp_event_irq_chk.sv
// Assertion checker for cmp_event_irq, attached by bind.
module cmp_event_irq_chk
    import cmp_event_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            raw,
    input logic            gie,
    input logic            ack,
    input logic            wr,
    input logic [WR_W-1:0] wdata,
    input logic [RD_W-1:0] rdata,
    input logic            irq,
    input logic            capt,
    input logic            evt,
    input logic            route
);
    logic [1:0] since_rst;

    // Count edges since reset, saturating, to guard the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: status is the raw input from two edges earlier
    p_sync_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (rdata[B_STAT] == $past(raw, 2)));

    // R3: reserved mode never sets a clear flag
    p_rsvd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[B_MODE_HI:B_MODE_LO] == 2'b01 && !rdata[B_FLAG]) |=> !rdata[B_FLAG]);

    // R6: an event beats a simultaneous clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && (ack || (wr && wdata[B_FLAG]))) |=> rdata[B_FLAG]);

    // R6: without a clear request the flag holds
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[B_FLAG] && !ack && !(wr && wdata[B_FLAG])) |=> rdata[B_FLAG]);

    // R7: a request needs the global enable and the flag
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && rdata[B_FLAG] && rdata[B_IEN]));

    // R9: no trigger while routing is off
    p_capt_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !route |-> !capt);
endmodule

bind cmp_event_irq cmp_event_irq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (cmp_raw_i),
    .gie   (gie_i),
    .ack   (irq_ack_i),
    .wr    (reg_wr_i),
    .wdata (reg_wdata_i),
    .rdata (reg_rdata_o),
    .irq   (irq_o),
    .capt  (capt_trig_o),
    .evt   (evt),
    .route (route_q)
);

// File: tb/cmp_event_irq_bench.sv
module cmp_event_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw_i = 1'b0;
    logic       gie_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [5:0] reg_wdata_i = '0;
    logic [6:0] reg_rdata_o;
    logic       irq_ack_i = 1'b0;
    logic       irq_o, ref_sel_o, capt_trig_o;
    int         n_chk = 0;
    int         n_err = 0;

    always #5 clk = ~clk;

    cmp_event_irq u_cmp_event_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_raw_i   (cmp_raw_i),
        .gie_i       (gie_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_ack_i   (irq_ack_i),
        .irq_o       (irq_o),
        .ref_sel_o   (ref_sel_o),
        .capt_trig_o (capt_trig_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Word layout: {clr, mode[1:0], route, ien, ref}
    task automatic wr(input logic clr, input logic [1:0] mode, input logic route,
                      input logic ien, input logic rsel);
        reg_wr_i = 1'b1;
        reg_wdata_i = {clr, mode, route, ien, rsel};
        tick(1);
        reg_wr_i = 1'b0;
        reg_wdata_i = '0;
    endtask

    task automatic ack_pulse();
        irq_ack_i = 1'b1;
        tick(1);
        irq_ack_i = 1'b0;
    endtask

    task automatic set_raw(input logic v);
        cmp_raw_i = v;
        tick(3);
    endtask

    function automatic logic flag();
        return reg_rdata_o[5];
    endfunction

    task automatic t_reset();
        chk("R10 reset rdata", reg_rdata_o, 0);
        chk("R10 reset irq", irq_o, 0);
        chk("R8 reset ref_sel", ref_sel_o, 0);
        chk("R9 reset capt", capt_trig_o, 0);
    endtask

    task automatic t_sync();
        wr(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        cmp_raw_i = 1'b1;
        tick(1);
        chk("R1 status after one edge", reg_rdata_o[6], 0);
        tick(1);
        chk("R1 status after two edges", reg_rdata_o[6], 1);
        set_raw(1'b0);
        chk("R1 status back low", reg_rdata_o[6], 0);
    endtask

    task automatic t_toggle();
        wr(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        set_raw(1'b1);
        chk("R2 toggle rise sets", flag(), 1);
        wr(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        chk("R6 w1c clears", flag(), 0);
        tick(3);
        chk("R2 steady level no reset", flag(), 0);
        set_raw(1'b0);
        chk("R2 toggle fall sets", flag(), 1);
        wr(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reserved();
        wr(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        set_raw(1'b1);
        chk("R3 reserved rise", flag(), 0);
        set_raw(1'b0);
        chk("R3 reserved fall", flag(), 0);
    endtask

    task automatic t_fall();
        wr(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        set_raw(1'b1);
        chk("R4 falling mode ignores rise", flag(), 0);
        set_raw(1'b0);
        chk("R4 falling mode sets", flag(), 1);
        wr(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_rise();
        wr(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        set_raw(1'b1);
        chk("R5 rising mode sets", flag(), 1);
        wr(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        set_raw(1'b0);
        chk("R5 rising mode ignores fall", flag(), 0);
    endtask

    task automatic t_clear();
        wr(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        set_raw(1'b1);
        wr(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        chk("R6 write zero keeps flag", flag(), 1);
        ack_pulse();
        chk("R6 ack clears", flag(), 0);
        set_raw(1'b0);
        // Event reaches the flag on the third edge; ack coincides with it.
        cmp_raw_i = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        irq_ack_i = 1'b1;
        tick(1);
        irq_ack_i = 1'b0;
        chk("R6 set wins over ack", flag(), 1);
        ack_pulse();
        chk("R6 ack after set-win", flag(), 0);
        set_raw(1'b0);
        wr(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_irq();
        wr(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        set_raw(1'b1);
        gie_i = 1'b1;
        tick(1);
        chk("R7 no local enable", irq_o, 0);
        wr(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
        gie_i = 1'b0;
        tick(1);
        chk("R7 no global enable", irq_o, 0);
        gie_i = 1'b1;
        tick(1);
        chk("R7 all set", irq_o, 1);
        ack_pulse();
        chk("R7 flag cleared", irq_o, 0);
        gie_i = 1'b0;
        set_raw(1'b0);
        wr(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_ref();
        wr(1'b0, 2'b01, 1'b0, 1'b0, 1'b1);
        chk("R8 ref select on", ref_sel_o, 1);
        wr(1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        chk("R8 ref select off", ref_sel_o, 0);
    endtask

    task automatic t_route();
        wr(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        set_raw(1'b1);
        chk("R9 routing off", capt_trig_o, 0);
        wr(1'b0, 2'b01, 1'b1, 1'b0, 1'b0);
        chk("R9 routing on high", capt_trig_o, 1);
        set_raw(1'b0);
        chk("R9 routing on low", capt_trig_o, 0);
    endtask

    task automatic t_readback();
        wr(1'b0, 2'b11, 1'b1, 1'b0, 1'b1);
        chk("R10 readback a", reg_rdata_o[4:0], 5'b11101);
        wr(1'b0, 2'b10, 1'b0, 1'b1, 1'b0);
        chk("R10 readback b", reg_rdata_o[4:0], 5'b10010);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_sync();
        t_toggle();
        t_reserved();
        t_fall();
        t_rise();
        t_clear();
        t_irq();
        t_ref();
        t_route();
        t_readback();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule